// File: doc/BRIEF.md
# Glitch-Tolerant Time-Slot Start Detector for a Single-Wire Bus Slave

This block sits at the front of a single-wire bus slave. It takes the raw, oversampled data line and produces one strobe at the start of every genuine time slot, together with a cleaned-up copy of the line level for the slot logic that follows. The line first passes through a two-flop synchronizer. At standard speed, a falling edge only counts once the line has stayed low for a programmable number of consecutive samples. This filter rejects short negative spikes on an otherwise idle line. At overdrive speed the filter is bypassed and a single low sample is enough.

Reflections and ringing on long or branched cabling often appear just after the line is released high. Each time the line returns high at the end of a slot, the block therefore opens a hold-off window of programmable length. Any low excursion that is over before the window closes is discarded, at either speed. A low level that is still present when the window runs out is taken as the start of the next slot. While a slot is in progress, no further start strobes are produced.

Top module: `ows_slot_detect`

## Requirements
- R1: While reset is asserted and right after it, `slot_start` is 0 and `line_filt` is 1. The block treats the line as idle high, with no hold-off running and no slot open.
- R2: At overdrive speed (`overdrive` = 1), a falling edge on an idle line gives a `slot_start` pulse exactly 3 clock cycles after the input changes. The pulse is one cycle wide.
- R3: At standard speed (`overdrive` = 0), a low excursion is accepted only when it lasts at least `filt_len` consecutive samples, where a value of 0 acts as 1. The strobe then appears `filt_len` + 2 cycles after the input falls. Shorter lows produce no strobe and leave `line_filt` at 1.
- R4: At overdrive speed, `filt_len` has no effect: a low lasting a single sample already starts a slot.
- R5: Exactly one strobe is produced per slot. No further strobe appears while the line stays low.
- R6: `line_filt` goes to 0 in the same cycle as the strobe and stays 0 until the line has gone high again. It returns to 1 three cycles after the input rises.
- R7: After a slot ends, a hold-off window of `holdoff_len` cycles opens. Low excursions that end inside this window are ignored at both speeds, even when they are long enough to pass the standard-speed filter.
- R8: A low level that is present when the hold-off window expires starts a new slot. At overdrive speed, or once the standard filter is already satisfied, the strobe comes exactly `holdoff_len` + 4 cycles after the input rose.
- R9: With `holdoff_len` = 0 there is no hold-off. A falling edge one cycle after the rise is accepted with the normal 3-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_in | input | 1 | Raw data line, asynchronous to clk |
| overdrive | input | 1 | 1 = overdrive speed (falling-edge filter bypassed), 0 = standard speed |
| filt_len | input | CW | Number of consecutive low samples required at standard speed (0 treated as 1) |
| holdoff_len | input | CW | Length of the hold-off window after each rise, in clock cycles |
| slot_start | output | 1 | One-cycle strobe at the start of each accepted time slot |
| line_filt | output | 1 | Filtered line level: 0 while a slot is open, 1 otherwise |

## Verification
Falling edges are applied on an idle line at both speeds. The delay to the strobe separates a design that includes the synchronizer and the filter from one that omits them. At standard speed, low pulses one sample shorter than the filter length and exactly equal to it are tried, which pins the filter threshold to the exact count. The same one-sample pulse is then used at overdrive, to show that the filter length is ignored there. After each rise, a mid-window glitch, a low that is held until the window closes, and a zero-length window each test a different point: whether rejection happens at all, the exact cycle of expiry, and whether a disabled window really lets an immediate edge through.

// File: rtl/ows_pkg.sv
`timescale 1ns/1ps
package ows_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SLOT = 2'd1,
    ST_HOLD = 2'd2
  } ows_state_e;
endpackage

// File: rtl/ows_rst_sync.sv
`timescale 1ns/1ps
module ows_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ows_sync2.sv
`timescale 1ns/1ps
module ows_sync2 #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ows_lowrun.sv
`timescale 1ns/1ps
// Counts consecutive low samples and flags when the run is long enough
// to qualify a falling edge for the current speed mode.
module ows_lowrun #(
  parameter int CW         = 8,
  parameter bit HAS_FILTER = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_s,
  input  logic          overdrive,
  input  logic [CW-1:0] filt_len,
  output logic          qualified
);
  localparam logic [CW-1:0] RUN_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;
  logic [CW-1:0] need;
  logic          run_en;

  generate
    if (HAS_FILTER) begin : g_filter
      always_comb begin
        if (overdrive || (filt_len == '0)) need = ONE;
        else                               need = filt_len;
      end
    end else begin : g_nofilter
      logic unused_cfg;
      assign unused_cfg = overdrive ^ (^filt_len);
      assign need = ONE;
    end
  endgenerate

  always_comb begin
    if (line_s)               run_d = '0;
    else if (run_q == RUN_MAX) run_d = run_q;
    else                      run_d = run_q + ONE;
    run_en = (run_d != run_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assign qualified = !line_s && (run_d >= need);
endmodule

// File: rtl/ows_holdoff.sv
`timescale 1ns/1ps
// Down-counter that times the hold-off window after each rising edge.
module ows_holdoff #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          done
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = len;
    else      cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == ONE) && !load;
endmodule

// File: rtl/ows_slot_detect.sv
`timescale 1ns/1ps
module ows_slot_detect #(
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_FILTER  = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_in,
  input  logic          overdrive,
  input  logic [CW-1:0] filt_len,
  input  logic [CW-1:0] holdoff_len,
  output logic          slot_start,
  output logic          line_filt
);
  import ows_pkg::*;

  logic       rst_n_i;
  logic       line_s;
  logic       qual;
  logic       ho_load;
  logic       ho_done;
  ows_state_e st_q, st_d;
  logic       strobe_q, strobe_d;
  logic       filt_q, filt_d;
  logic       hold_active;

  ows_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_i)
  );

  ows_sync2 #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     (line_in),
    .q     (line_s)
  );

  ows_lowrun #(.CW(CW), .HAS_FILTER(HAS_FILTER)) u_low (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .line_s    (line_s),
    .overdrive (overdrive),
    .filt_len  (filt_len),
    .qualified (qual)
  );

  ows_holdoff #(.CW(CW)) u_hold (
    .clk   (clk),
    .rst_n (rst_n_i),
    .load  (ho_load),
    .len   (holdoff_len),
    .done  (ho_done)
  );

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    strobe_d = 1'b0;
    ho_load  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (qual) begin
          strobe_d = 1'b1;
          st_d     = ST_SLOT;
        end
      end
      ST_SLOT: begin
        if (line_s) begin
          if (holdoff_len == '0) begin
            st_d = ST_IDLE;
          end else begin
            ho_load = 1'b1;
            st_d    = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (ho_done) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    filt_d = (st_d != ST_SLOT);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q     <= ST_IDLE;
      strobe_q <= 1'b0;
      filt_q   <= 1'b1;
    end else begin
      st_q     <= st_d;
      strobe_q <= strobe_d;
      filt_q   <= filt_d;
    end
  end

  assign hold_active = (st_q == ST_HOLD);
  assign slot_start  = strobe_q;
  assign line_filt   = filt_q;
endmodule

// File: rtl/ows_slot_detect_chk.sv
`timescale 1ns/1ps
module ows_slot_detect_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_in,
  input logic          overdrive,
  input logic [CW-1:0] filt_len,
  input logic          slot_start,
  input logic          line_filt,
  input logic          hold_active
);
  // R2: a strobe is always preceded by a low input sample three cycles before
  assert_low_before_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> ($past(line_in, 3) == 1'b0));

  // R3: at standard speed with a filter of two or more, two lows precede the strobe
  assert_filter_two_lows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && !$past(overdrive) && ($past(filt_len) >= CW'(2)))
      |-> ($past(line_in, 4) == 1'b0 && $past(line_in, 3) == 1'b0));

  // R5: the strobe never lasts more than one cycle
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> !slot_start);

  // R6: the filtered level is low whenever a strobe is issued
  assert_filt_low_at_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> !line_filt);

  // R7: no strobe can follow a cycle spent in the hold-off window
  assert_no_strobe_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |=> !slot_start);
endmodule

bind ows_slot_detect ows_slot_detect_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_in     (line_in),
  .overdrive   (overdrive),
  .filt_len    (filt_len),
  .slot_start  (slot_start),
  .line_filt   (line_filt),
  .hold_active (hold_active)
);

// File: tb/sim_ows_slot_detect.sv
`timescale 1ns/1ps
module sim_ows_slot_detect;
  localparam int CW = 8;
  localparam int H  = 20;

  logic          clk;
  logic          rst_n;
  logic          line_in;
  logic          overdrive;
  logic [CW-1:0] filt_len;
  logic [CW-1:0] holdoff_len;
  logic          slot_start;
  logic          line_filt;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int n_strobe = 0;
  int last_strobe = -1;
  bit finished = 0;

  ows_slot_detect #(.CW(CW)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_in     (line_in),
    .overdrive   (overdrive),
    .filt_len    (filt_len),
    .holdoff_len (holdoff_len),
    .slot_start  (slot_start),
    .line_filt   (line_filt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (slot_start) begin
      n_strobe++;
      last_strobe = cyc;
    end
  end

  task automatic check_eq(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_line(logic v, output int at);
    @(negedge clk);
    line_in = v;
    at = cyc;
  endtask

  // Opens a slot and releases it; returns the cycle of the rising input.
  task automatic run_slot(output int r);
    int f;
    set_line(1'b0, f);
    wait_cyc(6);
    set_line(1'b1, r);
  endtask

  task automatic t_reset();
    check_eq("R1 slot_start in reset", int'(slot_start), 0);
    check_eq("R1 line_filt in reset", int'(line_filt), 1);
    @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(6);
    check_eq("R1 slot_start after reset", int'(slot_start), 0);
    check_eq("R1 line_filt after reset", int'(line_filt), 1);
    check_eq("R1 no strobe after reset", n_strobe, 0);
  endtask

  task automatic t_od_edge();
    int base, f, r;
    overdrive = 1'b1;
    base = n_strobe;
    set_line(1'b0, f);
    wait_cyc(12);
    check_eq("R2 strobe latency", last_strobe - f, 3);
    check_eq("R5 one strobe on long low", n_strobe - base, 1);
    check_eq("R6 line_filt low in slot", int'(line_filt), 0);
    set_line(1'b1, r);
    wait_cyc(2);
    check_eq("R6 line_filt still low", int'(line_filt), 0);
    wait_cyc(1);
    check_eq("R6 line_filt back high", int'(line_filt), 1);
    wait_cyc(H + 10);
  endtask

  task automatic t_std_filter();
    int base, f, r;
    overdrive = 1'b0;
    filt_len  = CW'(4);
    base = n_strobe;
    set_line(1'b0, f);
    wait_cyc(2);
    set_line(1'b1, r);
    wait_cyc(10);
    check_eq("R3 short low rejected", n_strobe - base, 0);
    check_eq("R3 line_filt stays high", int'(line_filt), 1);
    set_line(1'b0, f);
    wait_cyc(3);
    set_line(1'b1, r);
    wait_cyc(10);
    check_eq("R3 exact-length low accepted", n_strobe - base, 1);
    check_eq("R3 filtered latency", last_strobe - f, 6);
    wait_cyc(H + 10);
    filt_len = '0;
    base = n_strobe;
    set_line(1'b0, f);
    set_line(1'b1, r);
    wait_cyc(10);
    check_eq("R3 zero length acts as one", n_strobe - base, 1);
    check_eq("R3 zero length latency", last_strobe - f, 3);
    wait_cyc(H + 10);
  endtask

  task automatic t_od_bypass();
    int base, f, r;
    overdrive = 1'b1;
    filt_len  = CW'(4);
    base = n_strobe;
    set_line(1'b0, f);
    set_line(1'b1, r);
    wait_cyc(10);
    check_eq("R4 one-sample low accepted", n_strobe - base, 1);
    check_eq("R4 bypass latency", last_strobe - f, 3);
    wait_cyc(H + 10);
  endtask

  task automatic t_hold_glitch(logic od);
    int base, r, g, e;
    overdrive = od;
    filt_len  = CW'(2);
    run_slot(r);
    wait_cyc(4);
    base = n_strobe;
    set_line(1'b0, g);
    wait_cyc(2);
    set_line(1'b1, e);
    wait_cyc(H + 10);
    check_eq(od ? "R7 glitch ignored overdrive" : "R7 glitch ignored standard",
             n_strobe - base, 0);
    check_eq("R7 line_filt high after glitch", int'(line_filt), 1);
  endtask

  task automatic t_hold_late(logic od);
    int base, r, g, e;
    overdrive = od;
    filt_len  = CW'(4);
    run_slot(r);
    wait_cyc(7);
    base = n_strobe;
    set_line(1'b0, g);
    wait_cyc(25);
    check_eq("R8 late low accepted", n_strobe - base, 1);
    check_eq("R8 strobe at window expiry", last_strobe - r, H + 4);
    set_line(1'b1, e);
    wait_cyc(H + 10);
  endtask

  task automatic t_hold_zero();
    int base, r, f, e;
    overdrive   = 1'b1;
    holdoff_len = '0;
    run_slot(r);
    base = n_strobe;
    set_line(1'b0, f);
    wait_cyc(8);
    check_eq("R9 immediate edge accepted", n_strobe - base, 1);
    check_eq("R9 latency without hold-off", last_strobe - f, 3);
    set_line(1'b1, e);
    wait_cyc(10);
    holdoff_len = CW'(H);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    line_in     = 1'b1;
    overdrive   = 1'b1;
    filt_len    = CW'(1);
    holdoff_len = CW'(H);
    wait_cyc(5);
    t_reset();
    t_od_edge();
    t_std_filter();
    t_od_bypass();
    t_hold_glitch(1'b1);
    t_hold_glitch(1'b0);
    t_hold_late(1'b1);
    t_hold_late(1'b0);
    t_hold_zero();
    finished = 1;
    summary();
    $finish;
  end
endmodule